// File: doc/BRIEF.md
# Borrow-Subtract Execution Unit

This block decodes and executes one 16-bit subtract-with-borrow instruction for a small CPU that has eight 24-bit general registers and a flag register. Instruction words arrive on a valid/ready stream, one per cycle. The carry flag acts as the incoming borrow. The 16-bit difference goes to the destination register with its upper eight bits cleared, and the arithmetic flags are updated.

A short chain of immediate-extension prefix words may come before the instruction. A prefix is marked by a tag input, not by its own encoding. With one prefix the instruction becomes "source minus a zero-extended 13-bit immediate". With two prefixes it becomes "source minus a 16-bit immediate". In both cases the source register, not the destination, supplies the minuend. Two conditional variants execute only when carry is set, or only when carry is clear. Otherwise they do nothing. A delay-slot input stands in for the branch unit: when it is high, any pending prefix is ignored.

The instruction port has a simple back-pressure rule. `in_ready` drops only in a cycle in which the register preload port or the flag preload port is active. A word is consumed only on an edge where `in_valid` and `in_ready` are both high. A producer must hold its word until that happens. The preload ports and the debug read port stand in for the rest of the CPU's datapath.

Top module: `sbc_exec_unit`

## Requirements
- R1: A non-prefix word with bits 15:10 = 001110 and variant bits 6:3 = 1011 is decoded as follows. Destination index is in bits 9:7 and source index in bits 2:0. With no pending prefix it writes dest[15:0] − src[15:0] − C into the destination and clears destination bits 23:16.
- R2: With exactly one pending prefix (payload = the low 13 bits of the prefix word), the result is src[15:0] − zero-extended payload − C, written to the destination. The source register is unchanged.
- R3: With two pending prefixes, the immediate is {first[2:0], second[12:0]} and the result is src[15:0] − imm16 − C. If a third consecutive prefix arrives, the oldest is dropped and the latest two form the immediate.
- R4: The unconditional variant sets the flags from the 16-bit subtraction. The flag bits are C (bit 0), V (bit 1), Z (bit 2) and N (bit 3). C = borrow, meaning the unsigned minuend < subtrahend + C. V = signed 16-bit overflow. Z = result is zero. N = result bit 15.
- R5: Variant 0011 executes only when C = 1, and variant 0111 only when C = 0. When executed, either one writes the result and updates V, Z and N, but leaves C as it was.
- R6: A conditional variant whose condition is false changes no register and no flag.
- R7: No instruction word changes the interrupt-enable flag (bit 4) or the interrupt level (bits 7:5). Only the flag preload port changes them.
- R8: When `in_delay_slot` is high on the instruction word, pending prefixes are ignored, the register form of R1 is used, and the chain is cleared.
- R9: Any accepted non-prefix word clears the prefix chain. A non-prefix word that does not match the opcode and a variant changes no register and no flag.
- R10: `in_ready` is low exactly while `reg_ld_en` or `psr_ld_en` is high. A word presented while not ready is not consumed. Accepted words take effect at the accepting edge, one per cycle, with no gap needed between dependent words.
- R11: After reset all registers, all flags and the prefix chain are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word is present |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_word | input | 16 | Instruction or prefix word |
| in_is_prefix | input | 1 | Tag: word is an immediate-extension prefix |
| in_delay_slot | input | 1 | Word sits in a branch delay slot |
| reg_ld_en | input | 1 | Preload a general register |
| reg_ld_addr | input | 3 | Register to preload |
| reg_ld_data | input | 24 | Preload value |
| psr_ld_en | input | 1 | Preload the flag register |
| psr_ld_data | input | 8 | Flag preload value |
| dbg_addr | input | 3 | Register index for the debug read |
| dbg_data | output | 24 | Contents of the selected register |
| flags | output | 8 | Flag register {IL[2:0], IE, N, Z, V, C} |

## Verification
The assertions assume three things about the inputs. The tag `in_is_prefix` is the only marker of a prefix. A word held against a low `in_ready` produces no flag change. The flag preload port is the sole other writer of the flag register. For that reason the interrupt-field and stall properties are written with the flag preload excluded from their antecedents. The stimulus raises the preload ports only in cycles it dedicates to setup. The one exception is a deliberate stall, where an instruction is presented alongside a register preload. The stimulus always marks prefixes with the tag and never uses the opcode pattern for them. Register indices for destination and source are kept distinct, so a checked result never aliases the unchanged-source check.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned PFX_LO_W = 13;
  localparam int unsigned PFX_HI_W = WORD_W - PFX_LO_W;

  localparam logic [5:0] OPC_SBC  = 6'b001110;
  localparam logic [3:0] VC_ALWAYS = 4'b1011;
  localparam logic [3:0] VC_IF_C   = 4'b0011;
  localparam logic [3:0] VC_IF_NC  = 4'b0111;

  localparam int unsigned FB_C  = 0;
  localparam int unsigned FB_V  = 1;
  localparam int unsigned FB_Z  = 2;
  localparam int unsigned FB_N  = 3;
  localparam int unsigned FB_IE = 4;
  localparam int unsigned FB_IL = 5;

  typedef enum logic [1:0] {
    VAR_ALWAYS = 2'd0,
    VAR_IF_C   = 2'd1,
    VAR_IF_NC  = 2'd2,
    VAR_NONE   = 2'd3
  } variant_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/sbc_prefix_chain.sv
module sbc_prefix_chain
  import sbc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                is_prefix,
  input  logic [PFX_LO_W-1:0] payload,
  output logic [1:0]          cnt,
  output logic [WORD_W-1:0]   imm
);
  logic [PFX_LO_W-1:0] older_q, newer_q;
  logic [1:0]          cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= 2'd0;
      older_q <= '0;
      newer_q <= '0;
    end else if (accept) begin
      if (!is_prefix) begin
        cnt_q <= 2'd0;
      end else begin
        case (cnt_q)
          2'd0: begin
            older_q <= payload;
            cnt_q   <= 2'd1;
          end
          2'd1: begin
            newer_q <= payload;
            cnt_q   <= 2'd2;
          end
          default: begin
            older_q <= newer_q;
            newer_q <= payload;
            cnt_q   <= 2'd2;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (cnt_q)
      2'd1:    imm = {{PFX_HI_W{1'b0}}, older_q};
      2'd2:    imm = {older_q[PFX_HI_W-1:0], newer_q};
      default: imm = '0;
    endcase
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sbc_decoder.sv
module sbc_decoder
  import sbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [WORD_W-1:0] word,
  input  logic              carry,
  output logic [ADDR_W-1:0] dst_idx,
  output logic [ADDR_W-1:0] src_idx,
  output logic              runs,
  output logic              upd_carry
);
  variant_e var_sel;
  logic     opc_hit;
  logic     cond_ok;

  assign opc_hit = (word[15:10] == OPC_SBC);
  assign dst_idx = word[7 +: ADDR_W];
  assign src_idx = word[0 +: ADDR_W];

  always_comb begin
    case (word[6:3])
      VC_ALWAYS: var_sel = VAR_ALWAYS;
      VC_IF_C:   var_sel = VAR_IF_C;
      VC_IF_NC:  var_sel = VAR_IF_NC;
      default:   var_sel = VAR_NONE;
    endcase
  end

  always_comb begin
    case (var_sel)
      VAR_ALWAYS: cond_ok = 1'b1;
      VAR_IF_C:   cond_ok = carry;
      VAR_IF_NC:  cond_ok = !carry;
      default:    cond_ok = 1'b0;
    endcase
  end

  assign runs      = opc_hit && cond_ok;
  assign upd_carry = (var_sel == VAR_ALWAYS);
endmodule

// File: rtl/sbc_sub_alu.sv
module sbc_sub_alu
  import sbc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]  minuend,
  input  logic [W-1:0]  subtrahend,
  input  logic          borrow_in,
  output logic [W-1:0]  diff,
  output arith_flags_t  fl
);
  logic [W:0] wide;

  assign wide = {1'b0, minuend} - {1'b0, subtrahend} - {{W{1'b0}}, borrow_in};
  assign diff = wide[W-1:0];

  always_comb begin
    fl.c = wide[W];
    fl.v = (minuend[W-1] != subtrahend[W-1]) && (diff[W-1] != minuend[W-1]);
    fl.z = (diff == '0);
    fl.n = diff[W-1];
  end
endmodule

// File: rtl/sbc_regfile.sv
module sbc_regfile #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned REG_W  = 24,
  parameter int unsigned OPND_W = 16,
  localparam int unsigned ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] ra_a,
  output logic [OPND_W-1:0] rd_a,
  input  logic [ADDR_W-1:0] ra_b,
  output logic [OPND_W-1:0] rd_b,
  input  logic [ADDR_W-1:0] ra_c,
  output logic [REG_W-1:0]  rd_c
);
  logic [REG_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (waddr == ADDR_W'(g)))
        regs[g] <= wdata;
    end
  end

  assign rd_a = regs[ra_a][OPND_W-1:0];
  assign rd_b = regs[ra_b][OPND_W-1:0];
  assign rd_c = regs[ra_c];
endmodule

// File: rtl/sbc_exec_unit.sv
module sbc_exec_unit
  import sbc_pkg::*;
#(
  parameter int unsigned NREG  = 8,
  parameter int unsigned REG_W = 24,
  parameter int unsigned IL_W  = 3,
  localparam int unsigned ADDR_W = $clog2(NREG),
  localparam int unsigned FLAG_W = FB_IL + IL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_is_prefix,
  input  logic              in_delay_slot,
  input  logic              reg_ld_en,
  input  logic [ADDR_W-1:0] reg_ld_addr,
  input  logic [REG_W-1:0]  reg_ld_data,
  input  logic              psr_ld_en,
  input  logic [FLAG_W-1:0] psr_ld_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [REG_W-1:0]  dbg_data,
  output logic [FLAG_W-1:0] flags
);
  logic              accept;
  logic [1:0]        pfx_cnt;
  logic [WORD_W-1:0] pfx_imm;
  logic [ADDR_W-1:0] dst_idx, src_idx;
  logic              dec_runs, upd_carry;
  logic [WORD_W-1:0] dst_val, src_val;
  logic              use_imm;
  logic [WORD_W-1:0] op_min, op_sub;
  logic [WORD_W-1:0] diff;
  arith_flags_t      alu_fl;
  logic              exec;
  logic [FLAG_W-1:0] flags_q;
  logic              rf_we;
  logic [ADDR_W-1:0] rf_waddr;
  logic [REG_W-1:0]  rf_wdata;

  assign in_ready = !(reg_ld_en || psr_ld_en);
  assign accept   = in_valid && in_ready;

  sbc_prefix_chain u_pfx (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .is_prefix (in_is_prefix),
    .payload   (in_word[PFX_LO_W-1:0]),
    .cnt       (pfx_cnt),
    .imm       (pfx_imm)
  );

  sbc_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .word      (in_word),
    .carry     (flags_q[FB_C]),
    .dst_idx   (dst_idx),
    .src_idx   (src_idx),
    .runs      (dec_runs),
    .upd_carry (upd_carry)
  );

  sbc_regfile #(.NREG(NREG), .REG_W(REG_W), .OPND_W(WORD_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra_a  (dst_idx),
    .rd_a  (dst_val),
    .ra_b  (src_idx),
    .rd_b  (src_val),
    .ra_c  (dbg_addr),
    .rd_c  (dbg_data)
  );

  // Prefix form: minuend from source, subtrahend from the immediate.
  assign use_imm = (pfx_cnt != 2'd0) && !in_delay_slot;
  assign op_min  = use_imm ? src_val : dst_val;
  assign op_sub  = use_imm ? pfx_imm : src_val;

  sbc_sub_alu #(.W(WORD_W)) u_alu (
    .minuend    (op_min),
    .subtrahend (op_sub),
    .borrow_in  (flags_q[FB_C]),
    .diff       (diff),
    .fl         (alu_fl)
  );

  assign exec = accept && !in_is_prefix && dec_runs;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dst_idx;
    rf_wdata = {{(REG_W-WORD_W){1'b0}}, diff};
    if (reg_ld_en) begin
      rf_we    = 1'b1;
      rf_waddr = reg_ld_addr;
      rf_wdata = reg_ld_data;
    end else if (exec) begin
      rf_we    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (psr_ld_en) begin
      flags_q <= psr_ld_data;
    end else if (exec) begin
      flags_q[FB_V] <= alu_fl.v;
      flags_q[FB_Z] <= alu_fl.z;
      flags_q[FB_N] <= alu_fl.n;
      if (upd_carry)
        flags_q[FB_C] <= alu_fl.c;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/sbc_exec_chk.sv
module sbc_exec_chk
  import sbc_pkg::*;
#(
  parameter int unsigned FLAG_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [5:0]        op_hi,
  input logic [3:0]        op_var,
  input logic              in_is_prefix,
  input logic              psr_ld_en,
  input logic [FLAG_W-1:0] flags,
  input logic [1:0]        pfx_cnt
);
  logic acc_insn;
  assign acc_insn = in_valid && in_ready && !in_is_prefix;

  AST_IFLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !psr_ld_en |=> $stable(flags[FLAG_W-1:FB_IE])); // R7

  AST_FALSE_COND_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_insn && op_hi == OPC_SBC &&
     ((op_var == VC_IF_C && !flags[FB_C]) || (op_var == VC_IF_NC && flags[FB_C])))
    |=> $stable(flags)); // R6

  AST_PFX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_insn |=> (pfx_cnt == 2'd0)); // R9

  AST_PFX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_cnt <= 2'd2); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !psr_ld_en) |=> $stable(flags)); // R10

  AST_COND_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_insn && op_hi == OPC_SBC && (op_var == VC_IF_C || op_var == VC_IF_NC))
    |=> $stable(flags[FB_C])); // R5
endmodule

bind sbc_exec_unit sbc_exec_chk #(.FLAG_W(FLAG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .op_hi        (in_word[15:10]),
  .op_var       (in_word[6:3]),
  .in_is_prefix (in_is_prefix),
  .psr_ld_en    (psr_ld_en),
  .flags        (flags),
  .pfx_cnt      (pfx_cnt)
);

// File: tb/test_sbc_exec_unit.sv
module test_sbc_exec_unit;
  localparam int CLK_P = 10;
  localparam int WD_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        in_is_prefix = 1'b0;
  logic        in_delay_slot = 1'b0;
  logic        reg_ld_en = 1'b0;
  logic [2:0]  reg_ld_addr = '0;
  logic [23:0] reg_ld_data = '0;
  logic        psr_ld_en = 1'b0;
  logic [7:0]  psr_ld_data = '0;
  logic [2:0]  dbg_addr = '0;
  logic [23:0] dbg_data;
  logic [7:0]  flags;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sbc_exec_unit i_sbc_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_is_prefix(in_is_prefix), .in_delay_slot(in_delay_slot),
    .reg_ld_en(reg_ld_en), .reg_ld_addr(reg_ld_addr), .reg_ld_data(reg_ld_data),
    .psr_ld_en(psr_ld_en), .psr_ld_data(psr_ld_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .flags(flags)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic [2:0]  rdi;
    logic [2:0]  rsi;
    logic [23:0] rdv;
    logic [23:0] rsv;
    logic        cin;
    logic [1:0]  npfx;
    logic [15:0] imm;
    logic [3:0]  vcode;
    logic        dly;
    logic [23:0] exp_rd;
    logic [3:0]  exp_nzvc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{4'd1, 3'd1, 3'd2, 24'h121000, 24'h000001, 1'b0, 2'd0, 16'h0000, 4'b1011, 1'b0, 24'h000FFF, 4'b0000}, // R1
    '{4'd4, 3'd3, 3'd4, 24'h000000, 24'h000001, 1'b1, 2'd0, 16'h0000, 4'b1011, 1'b0, 24'h00FFFE, 4'b1001}, // R4 borrow
    '{4'd4, 3'd0, 3'd7, 24'h008000, 24'h000001, 1'b0, 2'd0, 16'h0000, 4'b1011, 1'b0, 24'h007FFF, 4'b0010}, // R4 overflow
    '{4'd4, 3'd5, 3'd6, 24'h005555, 24'h005554, 1'b1, 2'd0, 16'h0000, 4'b1011, 1'b0, 24'h000000, 4'b0100}, // R4 zero
    '{4'd2, 3'd1, 3'd2, 24'hABCDEF, 24'h003000, 1'b0, 2'd1, 16'h1FFF, 4'b1011, 1'b0, 24'h001001, 4'b0000}, // R2
    '{4'd3, 3'd3, 3'd4, 24'h000000, 24'h44F000, 1'b1, 2'd2, 16'hE001, 4'b1011, 1'b0, 24'h000FFE, 4'b0000}, // R3
    '{4'd3, 3'd0, 3'd7, 24'h000000, 24'h000000, 1'b0, 2'd2, 16'h8000, 4'b1011, 1'b0, 24'h008000, 4'b1011}, // R3
    '{4'd5, 3'd2, 3'd5, 24'h000010, 24'h000005, 1'b1, 2'd0, 16'h0000, 4'b0011, 1'b0, 24'h00000A, 4'b0001}, // R5
    '{4'd6, 3'd2, 3'd5, 24'h330010, 24'h000005, 1'b0, 2'd0, 16'h0000, 4'b0011, 1'b0, 24'h330010, 4'b1110}, // R6
    '{4'd5, 3'd6, 3'd1, 24'h000000, 24'h000003, 1'b0, 2'd1, 16'h0005, 4'b0111, 1'b0, 24'h00FFFE, 4'b1000}, // R5
    '{4'd6, 3'd6, 3'd1, 24'h007777, 24'h000003, 1'b1, 2'd0, 16'h0000, 4'b0111, 1'b0, 24'h007777, 4'b1111}, // R6
    '{4'd8, 3'd1, 3'd2, 24'h000100, 24'h000001, 1'b0, 2'd2, 16'h1234, 4'b1011, 1'b1, 24'h0000FF, 4'b0000}  // R8
  };

  function automatic logic [15:0] enc(input logic [2:0] rd, input logic [3:0] vc, input logic [2:0] rs);
    return {6'b001110, rd, vc, rs};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; reg_ld_en = 0; psr_ld_en = 0; in_is_prefix = 0; in_delay_slot = 0;
  endtask

  task automatic ld_reg(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    in_valid = 0; psr_ld_en = 0; reg_ld_en = 1; reg_ld_addr = a; reg_ld_data = d;
  endtask

  task automatic ld_psr(input logic [7:0] d);
    @(negedge clk);
    in_valid = 0; reg_ld_en = 0; psr_ld_en = 1; psr_ld_data = d;
  endtask

  task automatic drive(input logic [15:0] w, input logic pfx, input logic dly);
    @(negedge clk);
    reg_ld_en = 0; psr_ld_en = 0;
    in_valid = 1; in_word = w; in_is_prefix = pfx; in_delay_slot = dly;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [23:0] v);
    dbg_addr = a;
    #1 v = dbg_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * WD_CYC);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk("R11 flags", 32'(flags), 32'h0);
    rd_reg(3'd3, v); chk("R11 reg", 32'(v), 32'h0);
    chk("R11 ready", 32'(in_ready), 32'h1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      vec_t t;
      string tg;
      t = TBL[i];
      tg = $sformatf("R%0d vec%0d", t.tag, i);
      ld_reg(t.rdi, t.rdv);
      ld_reg(t.rsi, t.rsv);
      ld_psr({3'b101, 1'b1, 3'b111, t.cin});
      if (t.npfx == 2'd1) drive({3'b0, t.imm[12:0]}, 1'b1, 1'b0);
      if (t.npfx == 2'd2) begin
        drive({13'b0, t.imm[15:13]}, 1'b1, 1'b0);
        drive({3'b0, t.imm[12:0]}, 1'b1, 1'b0);
      end
      drive(enc(t.rdi, t.vcode, t.rsi), 1'b0, t.dly);
      idle();
      rd_reg(t.rdi, v); chk({tg, " dest"}, 32'(v), 32'(t.exp_rd));
      rd_reg(t.rsi, v); chk({"R2 src kept ", tg}, 32'(v), 32'(t.rsv));
      chk({tg, " flags R7"}, 32'(flags), 32'({3'b101, 1'b1, t.exp_nzvc}));
    end

    // R10 stall: word presented with a register preload is not consumed
    ld_reg(3'd1, 24'h000009);
    ld_reg(3'd2, 24'h000001);
    ld_psr(8'h00);
    @(negedge clk);
    psr_ld_en = 0; reg_ld_en = 1; reg_ld_addr = 3'd5; reg_ld_data = 24'h0ABCDE;
    in_valid = 1; in_word = enc(3'd1, 4'b1011, 3'd2); in_is_prefix = 0;
    #1 chk("R10 ready low", 32'(in_ready), 32'h0);
    idle();
    rd_reg(3'd1, v); chk("R10 not consumed", 32'(v), 32'h000009);
    rd_reg(3'd5, v); chk("R10 preload", 32'(v), 32'h0ABCDE);
    chk("R10 flags", 32'(flags), 32'h0);

    // R9 chain cleared by a non-matching word, which itself has no effect
    ld_reg(3'd1, 24'h000050);
    ld_reg(3'd2, 24'h000010);
    ld_psr(8'h00);
    drive(16'h0003, 1'b1, 1'b0);
    drive(16'h0000, 1'b0, 1'b0);
    idle();
    rd_reg(3'd1, v); chk("R9 stray word reg", 32'(v), 32'h000050);
    chk("R9 stray word flags", 32'(flags), 32'h0);
    drive(enc(3'd1, 4'b1011, 3'd2), 1'b0, 1'b0);
    idle();
    rd_reg(3'd1, v); chk("R9 register form", 32'(v), 32'h000040);

    // R3 third prefix drops the oldest: imm = {010, 0x0004} = 0x4004
    ld_reg(3'd3, 24'h000000);
    ld_reg(3'd4, 24'h005000);
    ld_psr(8'h00);
    drive(16'h0001, 1'b1, 1'b0);
    drive(16'h0002, 1'b1, 1'b0);
    drive(16'h0004, 1'b1, 1'b0);
    drive(enc(3'd3, 4'b1011, 3'd4), 1'b0, 1'b0);
    idle();
    rd_reg(3'd3, v); chk("R3 third prefix", 32'(v), 32'h000FFC);

    // R4/R10 back-to-back borrow chain
    ld_reg(3'd1, 24'h000000);
    ld_reg(3'd2, 24'h000001);
    ld_reg(3'd3, 24'h000005);
    ld_reg(3'd4, 24'h000001);
    ld_psr(8'h00);
    drive(enc(3'd1, 4'b1011, 3'd2), 1'b0, 1'b0);
    drive(enc(3'd3, 4'b1011, 3'd4), 1'b0, 1'b0);
    idle();
    rd_reg(3'd1, v); chk("R4 chain low", 32'(v), 32'h00FFFF);
    rd_reg(3'd3, v); chk("R10 chain high", 32'(v), 32'h000003);
    chk("R4 chain flags", 32'(flags), 32'h0);

    idle();
    finish_run();
  end
endmodule